// File: doc/BRIEF.md
# Input Capture Conditioner

This block forms the receiving half of a timer capture channel. A raw, asynchronous pin is brought into the clock domain by a synchronizer chain. A digital noise filter then samples the pin at a programmable fraction of the clock and moves its clean output level only after a run of identical samples. One edge direction of that clean level is chosen as an event. A prescaler lets through only every first, second, fourth or eighth event. Each event that passes copies the running counter value into a capture register and raises a sticky capture flag.

A 4-bit filter code sets two things together: the sampling division (1, 2, 4, 8, 16 or 32 clocks) and the run length N. A 2-bit prescaler code picks the event ratio. A direction select enables the path: any nonzero value means the channel is an input. Software clears the flag and announces writes of the prescaler code through pulse inputs.

Top module: `icap_cond`

## Requirements
- R1: After reset, cap_val is 0 and cap_flag is 0.
- R2: Two synchronizer flops precede the filter. With filter code 0 (sample every clock, no filtering), a pin change driven before clock edge E1 makes the capture at edge E1+3, and the captured value is the count_val present at that edge.
- R3: The filtered level takes a new value only after N consecutive sampled values all differ from the current level. Any sample equal to the current level restarts the run.
- R4: filt_code maps to (sampling division, N) as follows. 0:(1,1) 1:(1,2) 2:(1,4) 3:(1,8) 4:(2,6) 5:(2,8) 6:(4,6) 7:(4,8) 8:(8,6) 9:(8,8) 10:(16,5) 11:(16,6) 12:(16,8) 13:(32,5) 14:(32,6) 15:(32,8). A pulse of (N-1)*division clocks is always rejected; a pulse of (N+1)*division clocks is always accepted.
- R5: psc_code 0, 1, 2 and 3 capture on every 1st, 2nd, 4th and 8th event, counting from the last capture or counter clear.
- R6: edge_fall=0 selects rising edges of the filtered level as events; edge_fall=1 selects falling edges. The other direction has no effect.
- R7: While dir_sel is 0, no capture happens, cap_val is unchanged, and the filter run counter and the prescaler event counter are cleared.
- R8: A psc_wr pulse clears the prescaler event counter. An event in that same cycle is discarded.
- R9: cap_flag stays set until a flag_clr pulse. A capture in the same cycle as flag_clr wins. cap_val changes only on a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | Raw asynchronous capture pin |
| count_val | input | CNT_W | Running timer counter value |
| filt_code | input | 4 | Filter code: sampling division and run length |
| psc_code | input | 2 | Event prescaler code |
| psc_wr | input | 1 | Pulse: prescaler code written, clears event count |
| edge_fall | input | 1 | 0 = rising edges count, 1 = falling edges count |
| dir_sel | input | 2 | Channel direction; nonzero = input capture enabled |
| flag_clr | input | 1 | Pulse: clear capture flag |
| cap_val | output | CNT_W | Captured counter value |
| cap_flag | output | 1 | Sticky capture flag |

## Verification
A single clean step with filtering off checks the exact pipeline latency, because the captured counter value encodes the capture cycle. For all sixteen filter codes, a pulse of (N-1)·division clocks and a pulse of (N+1)·division clocks are applied. These two pulses separate a correct run length and division from an off-by-one or wrong table entry, whatever the phase of the divider. A pulse pair split by a one-clock dip checks that the run restarts. Trains of L-1 and L pulses for each prescaler ratio, polarity pairs, prescaler-write interruptions and disabled-channel bursts show that counting, edge selection and gating work independently of each other.

// File: rtl/icap_pkg.sv
package icap_pkg;

   localparam int FILT_MAX_LOG2 = 5;

   typedef struct packed {
      logic [2:0] div_log2;
      logic [3:0] need;
   } filt_cfg_t;

   function automatic filt_cfg_t decode_filt(input logic [3:0] code);
      filt_cfg_t c;
      case (code)
         4'd0:    c = '{3'd0, 4'd1};
         4'd1:    c = '{3'd0, 4'd2};
         4'd2:    c = '{3'd0, 4'd4};
         4'd3:    c = '{3'd0, 4'd8};
         4'd4:    c = '{3'd1, 4'd6};
         4'd5:    c = '{3'd1, 4'd8};
         4'd6:    c = '{3'd2, 4'd6};
         4'd7:    c = '{3'd2, 4'd8};
         4'd8:    c = '{3'd3, 4'd6};
         4'd9:    c = '{3'd3, 4'd8};
         4'd10:   c = '{3'd4, 4'd5};
         4'd11:   c = '{3'd4, 4'd6};
         4'd12:   c = '{3'd4, 4'd8};
         4'd13:   c = '{3'd5, 4'd5};
         4'd14:   c = '{3'd5, 4'd6};
         default: c = '{3'd5, 4'd8};
      endcase
      return c;
   endfunction

endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("icap_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               chain[i] <= 1'b0;
            else if (i == 0)
               chain[i] <= d;
            else
               chain[i] <= chain[(i > 0) ? i - 1 : 0];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/icap_filter.sv
module icap_filter
   import icap_pkg::*;
#(
   parameter int DIV_W = FILT_MAX_LOG2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       smp,
   input  logic [3:0] code,
   output logic       lvl,
   output logic       strobe
);
   generate
      if (DIV_W < FILT_MAX_LOG2) begin : g_bad
         $error("icap_filter: DIV_W too narrow for the largest division");
      end
   endgenerate

   localparam int DIV_MOD = 1 << DIV_W;

   filt_cfg_t          cfg;
   logic [DIV_W-1:0]   div_cnt;
   logic [DIV_W-1:0]   div_mask;
   logic [3:0]         run_cnt;
   logic [3:0]         run_nxt;

   assign cfg      = decode_filt(code);
   assign div_mask = DIV_W'((DIV_MOD'(1) << cfg.div_log2) - 1);
   assign strobe   = ((div_cnt & div_mask) == '0);
   assign run_nxt  = run_cnt + 4'd1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         div_cnt <= '0;
      else
         div_cnt <= div_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl     <= 1'b0;
         run_cnt <= '0;
      end else if (!en) begin
         lvl     <= smp;
         run_cnt <= '0;
      end else if (strobe) begin
         if (smp == lvl) begin
            run_cnt <= '0;
         end else if (run_nxt >= cfg.need) begin
            lvl     <= smp;
            run_cnt <= '0;
         end else begin
            run_cnt <= run_nxt;
         end
      end
   end
endmodule

// File: rtl/icap_edge_psc.sv
module icap_edge_psc #(
   parameter int PSC_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             lvl,
   input  logic             edge_fall,
   input  logic [PSC_W-1:0] psc_code,
   input  logic             psc_wr,
   output logic             prev_lvl,
   output logic             fire
);
   localparam int MAX_RATIO = 1 << ((1 << PSC_W) - 1);
   localparam int CNT_W     = $clog2(MAX_RATIO) + 1;

   logic             evt;
   logic [CNT_W-1:0] ecnt;
   logic [CNT_W-1:0] lim_m1;

   assign evt    = en & (edge_fall ? (prev_lvl & ~lvl) : (lvl & ~prev_lvl));
   assign lim_m1 = CNT_W'((CNT_W'(1) << psc_code) - CNT_W'(1));
   assign fire   = evt & ~psc_wr & (ecnt == lim_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_lvl <= 1'b0;
         ecnt     <= '0;
      end else begin
         prev_lvl <= lvl;
         if (!en || psc_wr)
            ecnt <= '0;
         else if (evt)
            ecnt <= fire ? '0 : ecnt + 1'b1;
      end
   end
endmodule

// File: rtl/icap_cond.sv
module icap_cond
   import icap_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_in,
   input  logic [CNT_W-1:0] count_val,
   input  logic [3:0]       filt_code,
   input  logic [1:0]       psc_code,
   input  logic             psc_wr,
   input  logic             edge_fall,
   input  logic [1:0]       dir_sel,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] cap_val,
   output logic             cap_flag
);
   generate
      if (CNT_W < 1) begin : g_bad
         $error("icap_cond: CNT_W must be positive");
      end
   endgenerate

   logic chan_en;
   logic pin_sync;
   logic filt_lvl;
   logic filt_strobe;
   logic prev_lvl;
   logic cap_go;

   assign chan_en = (dir_sel != 2'd0);

   icap_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   icap_filter #(.DIV_W(FILT_MAX_LOG2)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (chan_en),
      .smp    (pin_sync),
      .code   (filt_code),
      .lvl    (filt_lvl),
      .strobe (filt_strobe)
   );

   icap_edge_psc #(.PSC_W(2)) u_psc (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (chan_en),
      .lvl       (filt_lvl),
      .edge_fall (edge_fall),
      .psc_code  (psc_code),
      .psc_wr    (psc_wr),
      .prev_lvl  (prev_lvl),
      .fire      (cap_go)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_val  <= '0;
         cap_flag <= 1'b0;
      end else if (cap_go) begin
         cap_val  <= count_val;
         cap_flag <= 1'b1;
      end else if (flag_clr) begin
         cap_flag <= 1'b0;
      end
   end
endmodule

// File: rtl/icap_cond_chk.sv
module icap_cond_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       dir_sel,
   input logic             flag_clr,
   input logic             edge_fall,
   input logic             cap_flag,
   input logic [CNT_W-1:0] cap_val,
   input logic             cap_go,
   input logic             lvl,
   input logic             prev_lvl,
   input logic             strobe
);
   p_no_cap_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(dir_sel) == 2'd0) |-> !$rose(cap_flag));

   p_val_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cap_val) |-> cap_flag);

   p_flag_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(flag_clr && !cap_go) |-> !cap_flag);

   p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cap_go) |-> cap_flag);

   p_lvl_on_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lvl) |-> $past(strobe || (dir_sel == 2'd0)));

   p_polarity_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cap_flag) && !$past(edge_fall)) |-> $past(lvl && !prev_lvl));
endmodule

bind icap_cond icap_cond_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .dir_sel   (dir_sel),
   .flag_clr  (flag_clr),
   .edge_fall (edge_fall),
   .cap_flag  (cap_flag),
   .cap_val   (cap_val),
   .cap_go    (cap_go),
   .lvl       (filt_lvl),
   .prev_lvl  (prev_lvl),
   .strobe    (filt_strobe)
);

// File: tb/tb_icap_cond.sv
`timescale 1ns/1ps
module tb_icap_cond;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         pin_in = 1'b0;
   logic [W-1:0] tcnt = '0;
   logic [3:0]   filt_code = 4'd0;
   logic [1:0]   psc_code = 2'd0;
   logic         psc_wr = 1'b0;
   logic         edge_fall = 1'b0;
   logic [1:0]   dir_sel = 2'd1;
   logic         flag_clr = 1'b0;
   logic [W-1:0] cap_val;
   logic         cap_flag;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   always #2 clk = ~clk;
   always @(negedge clk) tcnt <= tcnt + 1'b1;
   always @(posedge clk) cyc <= cyc + 1;

   icap_cond #(.CNT_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .count_val(tcnt),
      .filt_code(filt_code), .psc_code(psc_code), .psc_wr(psc_wr),
      .edge_fall(edge_fall), .dir_sel(dir_sel), .flag_clr(flag_clr),
      .cap_val(cap_val), .cap_flag(cap_flag)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_neg(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_flag();
      @(negedge clk) flag_clr = 1'b1;
      @(negedge clk) flag_clr = 1'b0;
   endtask

   task automatic write_psc(input logic [1:0] c);
      @(negedge clk) begin psc_code = c; psc_wr = 1'b1; end
      @(negedge clk) psc_wr = 1'b0;
   endtask

   task automatic pulse(input int hi, input int lo);
      @(negedge clk) pin_in = 1'b1;
      wait_neg(hi);
      pin_in = 1'b0;
      wait_neg(lo);
   endtask

   function automatic void table_of(input int code, output int d, output int n);
      case (code)
         0: begin d = 1; n = 1; end   1: begin d = 1; n = 2; end
         2: begin d = 1; n = 4; end   3: begin d = 1; n = 8; end
         4: begin d = 2; n = 6; end   5: begin d = 2; n = 8; end
         6: begin d = 4; n = 6; end   7: begin d = 4; n = 8; end
         8: begin d = 8; n = 6; end   9: begin d = 8; n = 8; end
         10: begin d = 16; n = 5; end 11: begin d = 16; n = 6; end
         12: begin d = 16; n = 8; end 13: begin d = 32; n = 5; end
         14: begin d = 32; n = 6; end default: begin d = 32; n = 8; end
      endcase
   endfunction

   task automatic t_reset();
      #1;
      check(cap_flag == 1'b0, "R1 flag", cap_flag, 0);
      check(cap_val == '0, "R1 value", cap_val, 0);
   endtask

   task automatic t_latency();
      logic [W-1:0] t0;
      filt_code = 4'd0; edge_fall = 1'b0;
      write_psc(2'd0);
      clear_flag();
      @(negedge clk) pin_in = 1'b1;
      #1 t0 = tcnt;
      wait_neg(6);
      check(cap_flag == 1'b1, "R2 flag", cap_flag, 1);
      check(cap_val == t0 + 3, "R2 latency", cap_val, t0 + 3);
      pin_in = 1'b0;
      wait_neg(6);
   endtask

   task automatic t_filter_table();
      int d, n;
      edge_fall = 1'b0;
      write_psc(2'd0);
      for (int c = 0; c < 16; c++) begin
         table_of(c, d, n);
         filt_code = 4'(c);
         wait_neg(n * d + 8);
         clear_flag();
         if (n > 1) begin
            pulse((n - 1) * d, (n + 2) * d + 8);
            check(cap_flag == 1'b0, $sformatf("R4 R3 code %0d short pulse", c), cap_flag, 0);
         end
         pulse((n + 1) * d, (n + 2) * d + 8);
         check(cap_flag == 1'b1, $sformatf("R4 code %0d long pulse", c), cap_flag, 1);
         clear_flag();
      end
   endtask

   task automatic t_run_restart();
      filt_code = 4'd3;
      wait_neg(12);
      clear_flag();
      pulse(5, 1);
      pulse(5, 14);
      check(cap_flag == 1'b0, "R3 broken run", cap_flag, 0);
      pulse(9, 14);
      check(cap_flag == 1'b1, "R3 full run", cap_flag, 1);
   endtask

   task automatic t_prescaler();
      filt_code = 4'd0; edge_fall = 1'b0;
      for (int c = 0; c < 4; c++) begin
         int lim;
         lim = 1 << c;
         write_psc(2'(c));
         clear_flag();
         for (int k = 0; k < lim - 1; k++) pulse(6, 6);
         check(cap_flag == 1'b0, $sformatf("R5 code %0d before limit", c), cap_flag, 0);
         pulse(6, 6);
         check(cap_flag == 1'b1, $sformatf("R5 code %0d at limit", c), cap_flag, 1);
      end
   endtask

   task automatic t_psc_wr();
      write_psc(2'd2);
      clear_flag();
      pulse(6, 6); pulse(6, 6);
      write_psc(2'd2);
      pulse(6, 6); pulse(6, 6); pulse(6, 6);
      check(cap_flag == 1'b0, "R8 count cleared", cap_flag, 0);
      pulse(6, 6);
      check(cap_flag == 1'b1, "R8 fourth after clear", cap_flag, 1);
   endtask

   task automatic t_polarity();
      logic [W-1:0] t0;
      write_psc(2'd0);
      edge_fall = 1'b1;
      clear_flag();
      @(negedge clk) pin_in = 1'b1;
      wait_neg(10);
      check(cap_flag == 1'b0, "R6 rising ignored", cap_flag, 0);
      pin_in = 1'b0;
      #1 t0 = tcnt;
      wait_neg(8);
      check(cap_flag == 1'b1, "R6 falling flag", cap_flag, 1);
      check(cap_val == t0 + 3, "R6 falling value", cap_val, t0 + 3);
      edge_fall = 1'b0;
      wait_neg(4);
   endtask

   task automatic t_disabled();
      logic [W-1:0] v0;
      write_psc(2'd1);
      clear_flag();
      pulse(6, 6);
      @(negedge clk) dir_sel = 2'd0;
      v0 = cap_val;
      pulse(6, 6); pulse(6, 6); pulse(6, 6);
      check(cap_flag == 1'b0, "R7 no flag while off", cap_flag, 0);
      check(cap_val == v0, "R7 value held", cap_val, v0);
      @(negedge clk) dir_sel = 2'd2;
      wait_neg(6);
      pulse(6, 6);
      check(cap_flag == 1'b0, "R7 prescaler cleared", cap_flag, 0);
      pulse(6, 6);
      check(cap_flag == 1'b1, "R7 counts after enable", cap_flag, 1);
   endtask

   task automatic t_flag_hold();
      logic [W-1:0] v0;
      v0 = cap_val;
      wait_neg(20);
      check(cap_flag == 1'b1, "R9 flag sticky", cap_flag, 1);
      check(cap_val == v0, "R9 value held", cap_val, v0);
      clear_flag();
      #1;
      check(cap_flag == 1'b0, "R9 flag cleared", cap_flag, 0);
      check(cap_val == v0, "R9 value after clear", cap_val, v0);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      wait_neg(3);
      t_reset();
      @(negedge clk) rst_n = 1'b1;
      wait_neg(4);
      t_latency();
      t_filter_table();
      t_run_restart();
      t_prescaler();
      t_psc_wr();
      t_polarity();
      t_disabled();
      t_flag_hold();
      finish_run();
   end

   initial begin
      wait (cyc > 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
   end
endmodule